// File: doc/BRIEF.md
# Heartbeat Watchdog with Low-Supply Alarm

This block checks that a processor is still running. It watches a heartbeat line that software toggles, and it pulls an active-low alarm output when the line has not changed for a set number of clock cycles. The alarm can drive an interrupt input. It can also be routed back to a manual-reset input so that a stalled processor gets reset.

The block brings in the heartbeat line through a two-flop synchroniser. A rising edge or a falling edge clears a saturating cycle counter. The counter is also held at zero in two cases: while the reset generator reports that reset is active, and while the heartbeat line is flagged as undriven. The undriven flag lets a board turn the watchdog off. In that mode the alarm only reports a low supply.

The supply-low indication forces the alarm low combinationally. When the supply recovers, the alarm returns high at once, with no minimum low time. The only exception is a timeout that is still pending, which keeps the alarm low.

Top module: `hb_watchdog`

## Requirements
- R1: With reset inactive, the line driven and no heartbeat edge, `alarm_n` goes low exactly TIMEOUT_CYCLES clock edges after the last edge at which the counter was cleared. It is high one edge earlier.
- R2: A heartbeat change in either direction clears the counter at the third clock edge after the change. With no further activity, `alarm_n` then falls TIMEOUT_CYCLES edges after that clearing edge.
- R3: While `rst_active` is 1, the counter is held at zero. An existing timeout is cleared at the next clock edge, and `alarm_n` stays high when the supply is good.
- R4: While `hb_undriven` is 1, the counter is held at zero. `alarm_n` then follows only `supply_low`.
- R5: After a timeout, `alarm_n` stays low until the watchdog is cleared by a heartbeat edge, by `rst_active`, or by `hb_undriven`.
- R6: The counter saturates at TIMEOUT_CYCLES. Holding the heartbeat still for many timeout periods keeps `alarm_n` low and never wraps it back high.
- R7: `supply_low` = 1 drives `alarm_n` low in the same cycle, whatever the counter holds.
- R8: When `supply_low` returns to 0, `alarm_n` goes high in the same cycle unless a timeout is pending. If one is pending, it stays low.
- R9: Heartbeat pulses that last at least two clock periods are each detected as edges that clear the counter.
- R10: While `rst_n` is low, the counter and the synchroniser flops are cleared. After release, `alarm_n` is high when the supply is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| hb_in | input | 1 | Heartbeat level from the processor (asynchronous) |
| hb_undriven | input | 1 | 1 when the heartbeat line is undriven; holds the counter cleared |
| rst_active | input | 1 | 1 while the system reset generator asserts reset |
| supply_low | input | 1 | 1 while the supply is below its threshold |
| alarm_n | output | 1 | Active-low watchdog alarm, also low on low supply |

## Verification
The bench targets several corner cases, each tied to a specific failure:

- **Exact timeout edge.** The bench checks the one cycle on each side of the timeout. An off-by-one counter compare, or a missing synchroniser stage, would move the fall by one cycle.
- **Saturation.** It holds the heartbeat still for three timeout periods. A counter that wraps would let the alarm return high.
- **Supply recovery.** It releases `supply_low` twice: once with a timeout pending and once without. A design that registered the supply path, or ignored the pending timeout, would return the alarm high at the wrong time.
- **Clearing sources.** It checks that each of reset, the undriven flag, and two-cycle heartbeat pulses clears the alarm. A design that missed the falling edge or ignored either hold input would time out while it should stay quiet.

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int TIMEOUT_CYCLES = 400_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_in,
  input  logic hb_undriven,
  input  logic rst_active,
  input  logic supply_low,
  output logic alarm_n
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(TIMEOUT_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hb_prev;
  logic [CW-1:0]          cnt;
  logic                   hb_edge, hold, expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      hb_prev <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], hb_in};
      hb_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign hb_edge = sync_q[SYNC_STAGES-1] ^ hb_prev;
  assign hold    = rst_active | hb_undriven;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (hold || hb_edge)    cnt <= '0;
    else if (cnt != TERM)        cnt <= cnt + CW'(1);
  end

  assign expired = (cnt == TERM);
  assign alarm_n = ~(expired | supply_low);

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hb_edge |=> cnt == '0); // R2
  AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> cnt == '0); // R3
  AST_UNDRIVEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    hb_undriven |=> cnt == '0); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !hb_edge && cnt != TERM) |=> cnt == $past(cnt) + CW'(1)); // R1
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !hold && !hb_edge) |=> expired); // R6
  AST_SUPPLY_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> !alarm_n); // R7
  AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_n && !supply_low && !hold && !hb_edge) |=> !alarm_n); // R5

endmodule

// File: tb/sim_hb_watchdog.sv
module sim_hb_watchdog;
  localparam int T = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hb_in = 1'b0, hb_undriven = 1'b0, rst_active = 1'b1, supply_low = 1'b0;
  logic alarm_n;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hb_watchdog #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .hb_undriven(hb_undriven),
    .rst_active(rst_active), .supply_low(supply_low), .alarm_n(alarm_n));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (alarm_n !== exp) begin
      failures++;
      $display("FAIL %s alarm_n=%b expected=%b at %0t", req, alarm_n, exp, $time);
    end
  endtask

  task automatic t_reset();
    step(3);
    chk("R10", 1'b1);
    rst_n = 1'b1;
    step(2);
    chk("R10", 1'b1);
    step(2 * T);
    chk("R3", 1'b1);
  endtask

  task automatic t_timeout();
    rst_active = 1'b0;
    step(T - 1);
    chk("R1", 1'b1);
    step(1);
    chk("R1", 1'b0);
    step(3 * T);
    chk("R6", 1'b0);
  endtask

  task automatic t_edge();
    hb_in = ~hb_in;
    step(2);
    chk("R5", 1'b0);
    step(1);
    chk("R2", 1'b1);
    step(T - 1);
    chk("R2", 1'b1);
    step(1);
    chk("R2", 1'b0);
    hb_in = ~hb_in;
    step(3);
    chk("R2", 1'b1);
    step(T);
    chk("R2", 1'b0);
  endtask

  task automatic t_sysreset();
    rst_active = 1'b1;
    step(1);
    chk("R3", 1'b1);
    step(2 * T);
    chk("R3", 1'b1);
  endtask

  task automatic t_undriven();
    hb_undriven = 1'b1;
    rst_active  = 1'b0;
    step(3 * T);
    chk("R4", 1'b1);
    supply_low = 1'b1;
    #1 chk("R7", 1'b0);
    step(2);
    chk("R4", 1'b0);
    supply_low = 1'b0;
    #1 chk("R8", 1'b1);
    step(1);
    hb_undriven = 1'b0;
    step(T - 1);
    chk("R1", 1'b1);
    step(1);
    chk("R1", 1'b0);
    supply_low = 1'b1;
    #1 chk("R7", 1'b0);
    step(1);
    supply_low = 1'b0;
    #1 chk("R8", 1'b0);
    step(1);
    hb_undriven = 1'b1;
    step(1);
    chk("R5", 1'b1);
    hb_undriven = 1'b0;
  endtask

  task automatic t_pulses();
    for (int i = 0; i < 8; i++) begin
      hb_in = 1'b1;
      step(2);
      hb_in = 1'b0;
      step(T / 2 + 4);
      chk("R9", 1'b1);
    end
    step(T + 3);
    chk("R9", 1'b0);
  endtask

  initial begin
    t_reset();
    t_timeout();
    t_edge();
    t_sysreset();
    t_undriven();
    t_pulses();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule